// File: doc/BRIEF.md
# Dual-bank shared SRAM arbiter

This block places two bus masters, port A and port B, in front of one on-chip SRAM that is split into two banks. Both masters run on one common clock. Each master drives a request with a word address, a write flag, per-byte write enables and write data. It gets back a ready strobe, registered read data and a read-valid flag.

The most significant address bit picks the bank. Each bank has its own two-way arbiter. When the two masters address different banks in a cycle, both are served in that cycle. When they address the same bank, one master is served and the other sees ready low. The stalled master keeps its request, address, write flag, byte enables and data unchanged until ready rises, so no access is dropped. Same-bank conflicts are settled round-robin per bank. Both banks are plain synchronous arrays written so that block RAM can be inferred.

Top module: `dual_bank_sram_arb`

## Requirements
- R1: Address bit ADDR_W-1 selects the bank (0 = lower bank, 1 = upper bank). The remaining low bits select a word inside that bank, so every address maps to exactly one stored word.
- R2: When both ports request in a cycle and their bank bits differ, both `a_ready` and `b_ready` are high in that cycle.
- R3: When both ports request the same bank in a cycle, exactly one of `a_ready`/`b_ready` is high.
- R4: After reset, port A wins the first same-bank conflict on each bank. After that, on each bank, the port that lost the previous conflict on that bank wins the next one.
- R5: A read is accepted in a cycle where request and ready are high and the write flag is low. In the following cycle, the port's rvalid is high and its rdata holds the word stored at that address. In every other cycle, rvalid is low.
- R6: An accepted write changes only the byte lanes whose enable bit is set. Enable bit i covers data bits 8*i+7 down to 8*i.
- R7: A stalled port that holds its request stable is served in a later cycle. Its write takes effect, or its read returns data, exactly once.
- R8: While reset is high and in the first cycle after it, both rvalid outputs are low.
- R9: A port's ready is low in any cycle in which its request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports and both banks |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Port A access request |
| a_addr | input | ADDR_W | Port A word address, top bit selects the bank |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | DATA_W/8 | Port A byte enables for writes |
| a_wdata | input | DATA_W | Port A write data |
| a_ready | output | 1 | Port A access accepted this cycle |
| a_rdata | output | DATA_W | Port A read data, valid with a_rvalid |
| a_rvalid | output | 1 | Port A read data valid (one cycle after acceptance) |
| b_req | input | 1 | Port B access request |
| b_addr | input | ADDR_W | Port B word address, top bit selects the bank |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | DATA_W/8 | Port B byte enables for writes |
| b_wdata | input | DATA_W | Port B write data |
| b_ready | output | 1 | Port B access accepted this cycle |
| b_rdata | output | DATA_W | Port B read data, valid with b_rvalid |
| b_rvalid | output | 1 | Port B read data valid (one cycle after acceptance) |

## Verification
Two functions meet in one cycle when one port is granted a bank while the other port's access falls in the same cycle. On different banks, both accesses are served together, and a write on one port can coincide with a read on the other. On the same bank, the loser stalls and is served in a later cycle. The bench first fills both banks with simultaneous writes to opposite banks. It then forces runs of same-bank conflicts with mixed reads and writes. Finally it drives random traffic with random byte enables, holding any stalled request stable. A behavioural model tracks both banks, the per-bank priority and the pending read returns. It predicts each port's ready and next-cycle rvalid and rdata, and these are compared on every clock.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
  localparam int NUM_PORTS = 2;
  localparam int NUM_BANKS = 2;
  localparam int LANE_W    = 8;

  // index of a requesting master
  typedef logic [0:0] port_idx_t;
endpackage

// File: rtl/sram_bank_arb.sv
module sram_bank_arb
  import sram_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] want,
  output logic [NUM_PORTS-1:0] grant
);
  port_idx_t favour_q;
  logic      clash;

  assign clash = &want;

  always_comb begin
    if (clash) begin
      grant = '0;
      grant[favour_q] = 1'b1;
    end else begin
      grant = want;
    end
  end

  // loser of a conflict becomes the favoured port for the next conflict
  always_ff @(posedge clk) begin
    if (rst)        favour_q <= '0;
    else if (clash) favour_q <= ~favour_q;
  end
endmodule

// File: rtl/sram_bank_ram.sv
module sram_bank_ram
  import sram_arb_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [DW/8-1:0]  be,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int LANES = DW / LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int i = 0; i < LANES; i++) begin
        if (be[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
    if (en && !we) rdata <= mem[addr];
  end
endmodule

// File: rtl/dual_bank_sram_arb.sv
module dual_bank_sram_arb
  import sram_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                a_req,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic                a_we,
  input  logic [DATA_W/8-1:0] a_be,
  input  logic [DATA_W-1:0]   a_wdata,
  output logic                a_ready,
  output logic [DATA_W-1:0]   a_rdata,
  output logic                a_rvalid,
  input  logic                b_req,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic                b_we,
  input  logic [DATA_W/8-1:0] b_be,
  input  logic [DATA_W-1:0]   b_wdata,
  output logic                b_ready,
  output logic [DATA_W-1:0]   b_rdata,
  output logic                b_rvalid
);
  localparam int BANK_AW = ADDR_W - 1;
  localparam int BE_W    = DATA_W / LANE_W;
  localparam int MSB     = ADDR_W - 1;

  logic [NUM_PORTS-1:0] p_req, p_we, p_ready;
  logic [ADDR_W-1:0]    p_addr  [NUM_PORTS];
  logic [BE_W-1:0]      p_be    [NUM_PORTS];
  logic [DATA_W-1:0]    p_wdata [NUM_PORTS];

  logic [NUM_PORTS-1:0] bank_grant [NUM_BANKS];
  logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

  logic [NUM_PORTS-1:0] rv_q;
  logic [NUM_PORTS-1:0] rbank_q;

  assign p_req      = {b_req, a_req};
  assign p_we       = {b_we, a_we};
  assign p_addr[0]  = a_addr;
  assign p_addr[1]  = b_addr;
  assign p_be[0]    = a_be;
  assign p_be[1]    = b_be;
  assign p_wdata[0] = a_wdata;
  assign p_wdata[1] = b_wdata;

  for (genvar bk = 0; bk < NUM_BANKS; bk++) begin : g_bank
    logic [NUM_PORTS-1:0] want;
    port_idx_t            sel;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_want
      assign want[p] = p_req[p] && (p_addr[p][MSB] == 1'(bk));
    end

    sram_bank_arb u_arb (
      .clk   (clk),
      .rst   (rst),
      .want  (want),
      .grant (bank_grant[bk])
    );

    assign sel = port_idx_t'(bank_grant[bk][1]);

    sram_bank_ram #(.AW(BANK_AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .en    (|bank_grant[bk]),
      .we    (p_we[sel]),
      .be    (p_be[sel]),
      .addr  (p_addr[sel][BANK_AW-1:0]),
      .wdata (p_wdata[sel]),
      .rdata (bank_rdata[bk])
    );
  end

  // each port targets one bank, so its ready is the OR of that port's grants
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign p_ready[p] = bank_grant[0][p] | bank_grant[1][p];

    always_ff @(posedge clk) begin
      if (rst) rv_q[p] <= 1'b0;
      else     rv_q[p] <= p_ready[p] & ~p_we[p];
      rbank_q[p] <= p_addr[p][MSB];
    end
  end

  assign a_ready  = p_ready[0];
  assign b_ready  = p_ready[1];
  assign a_rvalid = rv_q[0];
  assign b_rvalid = rv_q[1];
  assign a_rdata  = bank_rdata[rbank_q[0]];
  assign b_rdata  = bank_rdata[rbank_q[1]];
endmodule

// File: rtl/sram_arb_checker.sv
module sram_arb_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              a_req,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_we,
  input logic              a_ready,
  input logic              a_rvalid,
  input logic              b_req,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_we,
  input logic              b_ready,
  input logic              b_rvalid
);
  logic same_bank, clash;
  assign same_bank = a_addr[ADDR_W-1] == b_addr[ADDR_W-1];
  assign clash     = a_req && b_req && same_bank;

  p_idle_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (!a_req |-> !a_ready) and (!b_req |-> !b_ready));

  p_split_both_served_r2: assert property (@(posedge clk) disable iff (rst)
    (a_req && b_req && !same_bank) |-> (a_ready && b_ready));

  p_clash_single_grant_r3: assert property (@(posedge clk) disable iff (rst)
    clash |-> (a_ready ^ b_ready));

  p_clash_alternates_r4: assert property (@(posedge clk) disable iff (rst)
    (clash && $past(clash) && !$past(rst)
     && (a_addr[ADDR_W-1] == $past(a_addr[ADDR_W-1]))) |-> (a_ready != $past(a_ready)));

  p_read_returns_r5: assert property (@(posedge clk) disable iff (rst)
    (a_req && a_ready && !a_we) |=> a_rvalid);

  p_no_spurious_rvalid_r5: assert property (@(posedge clk) disable iff (rst)
    !(b_req && b_ready && !b_we) |=> !b_rvalid);
endmodule

bind dual_bank_sram_arb sram_arb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .a_req(a_req), .a_addr(a_addr), .a_we(a_we), .a_ready(a_ready), .a_rvalid(a_rvalid),
  .b_req(b_req), .b_addr(b_addr), .b_we(b_we), .b_ready(b_ready), .b_rvalid(b_rvalid)
);

// File: tb/dual_bank_sram_arb_test.sv
module dual_bank_sram_arb_test;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int WORDS = 1 << AW;
  localparam int HALF = WORDS / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          a_req = 0, b_req = 0, a_we = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [BW-1:0] a_be = '0, b_be = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic          a_ready, b_ready, a_rvalid, b_rvalid;
  logic [DW-1:0] a_rdata, b_rdata;

  dual_bank_sram_arb #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_addr(a_addr), .a_we(a_we), .a_be(a_be), .a_wdata(a_wdata),
    .a_ready(a_ready), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_req(b_req), .b_addr(b_addr), .b_we(b_we), .b_be(b_be), .b_wdata(b_wdata),
    .b_ready(b_ready), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] model [WORDS];
  bit            favour [2];
  bit            held [2];
  bit            exp_rv [2];
  logic [DW-1:0] exp_rd [2];

  // per-port stimulus
  bit            s_req [2];
  bit            s_we [2];
  logic [AW-1:0] s_addr [2];
  logic [BW-1:0] s_be [2];
  logic [DW-1:0] s_wd [2];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive();
    a_req = s_req[0]; a_we = s_we[0]; a_addr = s_addr[0]; a_be = s_be[0]; a_wdata = s_wd[0];
    b_req = s_req[1]; b_we = s_we[1]; b_addr = s_addr[1]; b_be = s_be[1]; b_wdata = s_wd[1];
  endtask

  // one clock of traffic; mode 0 = fill, 1 = same-bank clash, 2 = random
  task automatic step(input int mode, input int idx);
    bit g [2];
    bit got_rv [2];
    logic [DW-1:0] got_rd [2];
    @(negedge clk);
    got_rv[0] = a_rvalid; got_rv[1] = b_rvalid;
    got_rd[0] = a_rdata;  got_rd[1] = b_rdata;
    for (int p = 0; p < 2; p++) begin
      chk(got_rv[p] == exp_rv[p], "R5 rvalid", DW'(got_rv[p]), DW'(exp_rv[p]));
      if (exp_rv[p]) chk(got_rd[p] === exp_rd[p], "R5 R6 R7 R1 rdata", got_rd[p], exp_rd[p]);
    end
    for (int p = 0; p < 2; p++) begin
      if (held[p]) continue;
      case (mode)
        0: begin
          s_req[p] = 1; s_we[p] = 1; s_be[p] = '1;
          s_addr[p] = AW'(p * HALF + idx); s_wd[p] = {$urandom};
        end
        1: begin
          s_req[p] = ($urandom % 8) != 0; s_we[p] = $urandom % 2; s_be[p] = BW'($urandom);
          s_addr[p] = AW'({idx[0], 4'($urandom)}); s_wd[p] = {$urandom};
        end
        default: begin
          s_req[p] = ($urandom % 4) != 0; s_we[p] = $urandom % 2; s_be[p] = BW'($urandom);
          s_addr[p] = AW'($urandom); s_wd[p] = {$urandom};
        end
      endcase
    end
    drive();
    #1;
    // expected grants
    g[0] = s_req[0]; g[1] = s_req[1];
    if (s_req[0] && s_req[1] && s_addr[0][AW-1] == s_addr[1][AW-1]) begin
      int bk;
      bk = int'(s_addr[0][AW-1]);
      g[0] = (favour[bk] == 0);
      g[1] = (favour[bk] == 1);
      favour[bk] = !favour[bk];
      chk(a_ready == g[0] && b_ready == g[1], "R3 R4 ready", DW'({a_ready, b_ready}), DW'({g[0], g[1]}));
    end else begin
      chk(a_ready == g[0], "R2 R9 a_ready", DW'(a_ready), DW'(g[0]));
      chk(b_ready == g[1], "R2 R9 b_ready", DW'(b_ready), DW'(g[1]));
    end
    for (int p = 0; p < 2; p++) begin
      exp_rv[p] = g[p] && !s_we[p];
      if (g[p] && s_we[p]) begin
        for (int i = 0; i < BW; i++)
          if (s_be[p][i]) model[s_addr[p]][i*8 +: 8] = s_wd[p][i*8 +: 8];
      end else if (g[p]) begin
        exp_rd[p] = model[s_addr[p]];
      end
      held[p] = s_req[p] && !g[p];
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      favour[p] = 0; held[p] = 0; exp_rv[p] = 0; exp_rd[p] = '0;
      s_req[p] = 0; s_we[p] = 0; s_addr[p] = '0; s_be[p] = '0; s_wd[p] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!a_rvalid && !b_rvalid, "R8 rvalid in reset", DW'({a_rvalid, b_rvalid}), '0);
    chk(!a_ready && !b_ready, "R9 ready in reset", DW'({a_ready, b_ready}), '0);
    rst = 0;
    @(negedge clk);
    chk(!a_rvalid && !b_rvalid, "R8 rvalid after reset", DW'({a_rvalid, b_rvalid}), '0);
    // fill both banks at once: A lower, B upper (R2, R1)
    for (int i = 0; i < HALF; i++) step(0, i);
    // same-bank conflicts, bank alternating in runs (R3, R4, R7)
    for (int i = 0; i < 400; i++) step(1, i / 20);
    // random traffic with byte enables (R6)
    for (int i = 0; i < 3000; i++) step(2, i);
    // drain: no requests, last read returns
    for (int p = 0; p < 2; p++) begin held[p] = 0; end
    s_req[0] = 0; s_req[1] = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(a_rvalid == exp_rv[0] && b_rvalid == exp_rv[1], "R5 drain rvalid",
          DW'({a_rvalid, b_rvalid}), DW'({exp_rv[0], exp_rv[1]}));
      if (exp_rv[0]) chk(a_rdata === exp_rd[0], "R5 drain a_rdata", a_rdata, exp_rd[0]);
      if (exp_rv[1]) chk(b_rdata === exp_rd[1], "R5 drain b_rdata", b_rdata, exp_rd[1]);
      drive();
      exp_rv[0] = 0; exp_rv[1] = 0;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule